// File: doc/BRIEF.md
# Run-length video pixel decoder

This block expands a stream of 16-bit run-length words into one 6-bit colour per displayed pixel. Words arrive from a small input queue through a valid/ready handshake. A display timing generator supplies a per-pixel active strobe and a frame-start pulse. The block produces a registered colour and a pixel-enable that follows the active strobe by one cycle. Flash access and sync generation belong to other blocks. Towards the stream source the block only raises a one-cycle rewind request that carries a word address.

An ordinary word holds a run length in bits [15:6] and a colour in bits [5:0]. The colour is painted across that many consecutive active pixels, and every row is closed by a run that ends on its last column. Two control codes are carried in the same stream. A row-repeat code asks for the row just drawn to be shown again some number of times. A stop code halts decoding until the next frame, which then plays again from word address 0. A frame-repeat input shows each decoded frame twice, which halves the content rate. Replays work by rewinding the source to the stored start address of the row or of the frame.

Top module: `rle_video_decoder`

## Requirements
- R1: A run word, whose run field (bits [15:6]) lies between 1 and LINE_PIXELS, paints its colour (bits [5:0]) on exactly that many consecutive active pixels. The registered result appears on `pix_colour` one cycle after each active pixel.
- R2: `pix_de` equals `pix_active` delayed by one cycle, and `pix_colour` is 0 whenever `pix_de` is low.
- R3: An active pixel that finds no run loaded is output as colour 0. This covers pixels before the first frame start, pixels while waiting after a rewind, and pixels after a stop.
- R4: A word whose bits [15:11] are all ones, other than 0xFFC0, is a row-repeat code with count N in bits [10:0]. When it follows the final run of a row, that row is shown N further times. Before each further showing, a rewind to the address of the row's first run word is issued. N = 0 has no visible effect.
- R5: The word 0xFFC0 stops the decoder, and `word_ready` stays low until the next frame start. At that frame start a rewind to address 0 is issued, unless R6 applies first.
- R6: If `frame_repeat` is high at a frame start that ends the first showing of a frame, a rewind to that frame's first word address is issued and the frame is shown again. The frame after a second showing always continues with new content.
- R7: A rewind request lasts exactly one cycle, and `word_ready` is low during it. The block treats the word presented in the next cycle as the word at `rewind_addr`.
- R8: A word that is neither a run, a repeat code nor the stop code (run field 0, or above LINE_PIXELS) is accepted and discarded without painting any pixel.
- R9: After reset, `pix_de`, `pix_colour` and `rewind_req` are 0. The next fetch address is 0, and no run word is accepted before the first frame start.
- R10: Once FRAME_ROWS rows of a frame have been shown, run words are held unaccepted until the next frame start. Control words can still be accepted during this time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Stream word available |
| word_data | input | 16 | Stream word |
| word_ready | output | 1 | Word accepted when high together with word_valid |
| pix_active | input | 1 | Current cycle is a pixel inside the visible area |
| frame_start | input | 1 | One-cycle pulse in vertical blanking before the first row |
| frame_repeat | input | 1 | Show every frame twice |
| rewind_req | output | 1 | One-cycle request to restart the stream at rewind_addr |
| rewind_addr | output | ADDR_W | Word address to restart from |
| pix_colour | output | 6 | Registered pixel colour |
| pix_de | output | 1 | Registered pixel enable |

## Verification
The assertions rely on three properties of the inputs. `frame_start` never lands in the cycle right after a rewind. Runs never cross a row end. Horizontal blanking lasts at least three cycles, which leaves room to take a repeat code, issue the rewind and fetch again. The bench's stream source follows a rewind on the same edge as the block and keeps `word_valid` high. Its rows always close exactly on the last column. Every control word and every rewind is placed in blanking, where six idle cycles separate the rows and four idle cycles follow each frame start.

// File: rtl/rlv_pkg.sv
// Shared constants, word classes and widths for the run-length video decoder.
// Assumes 16-bit stream words with a 10-bit run field above a 6-bit colour.
package rlv_pkg;
    localparam int WORD_W   = 16;
    localparam int COLOUR_W = 6;
    localparam int RUN_W    = WORD_W - COLOUR_W;
    localparam int REP_W    = 11;
    localparam logic [WORD_W-1:0] STOP_CODE = 16'hFFC0;
    localparam logic [4:0]        REP_MARK  = 5'b11111;

    typedef enum logic [1:0] {
        WK_RUN    = 2'd0,
        WK_REPEAT = 2'd1,
        WK_STOP   = 2'd2,
        WK_OTHER  = 2'd3
    } word_kind_e;
endpackage

// File: rtl/rlv_word_class.sv
// Splits a stream word into run length, colour and repeat count, and sorts it
// into one of four classes. Assumes LINE_PIXELS is below 992, so that real
// runs never collide with the control codes.
module rlv_word_class
    import rlv_pkg::*;
#(
    parameter int LINE_PIXELS = 640
) (
    input  logic [WORD_W-1:0]   word,
    output word_kind_e          kind,
    output logic [RUN_W-1:0]    run_len,
    output logic [COLOUR_W-1:0] colour,
    output logic [REP_W-1:0]    rep_count
);
    localparam logic [RUN_W-1:0] MAX_RUN = RUN_W'(LINE_PIXELS);

    assign run_len   = word[WORD_W-1:COLOUR_W];
    assign colour    = word[COLOUR_W-1:0];
    assign rep_count = word[REP_W-1:0];

    // Classify: stop code first, then repeat marker, then legal run length.
    always_comb begin
        if (word == STOP_CODE)
            kind = WK_STOP;
        else if (word[WORD_W-1:WORD_W-5] == REP_MARK)
            kind = WK_REPEAT;
        else if (run_len != '0 && run_len <= MAX_RUN)
            kind = WK_RUN;
        else
            kind = WK_OTHER;
    end
endmodule

// File: rtl/rlv_raster_track.sv
// Follows the raster: counts active pixels in a row and shown rows in a frame.
// Assumes every row has exactly LINE_PIXELS active cycles. The frame is marked
// complete after FRAME_ROWS rows and stays complete until frame_start, which is
// also the state after reset.
module rlv_raster_track #(
    parameter int LINE_PIXELS = 640,
    parameter int FRAME_ROWS  = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_active,
    input  logic frame_start,
    output logic at_row_start,
    output logic at_row_last,
    output logic frame_done
);
    localparam int CW = $clog2(LINE_PIXELS);
    localparam int RW = (FRAME_ROWS > 1) ? $clog2(FRAME_ROWS) : 1;
    localparam logic [CW-1:0] COL_LAST = CW'(LINE_PIXELS - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(FRAME_ROWS - 1);

    logic [CW-1:0] col_q;
    logic [RW-1:0] row_q;
    logic          done_q;

    assign at_row_start = (col_q == '0);
    assign at_row_last  = (col_q == COL_LAST);
    assign frame_done   = done_q;

    // Column and row counting; frame_start re-arms the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            row_q  <= '0;
            done_q <= 1'b1;
        end else if (frame_start) begin
            col_q  <= '0;
            row_q  <= '0;
            done_q <= 1'b0;
        end else if (pix_active) begin
            if (col_q == COL_LAST) begin
                col_q <= '0;
                if (!done_q) begin
                    if (row_q == ROW_LAST) begin
                        row_q  <= '0;
                        done_q <= 1'b1;
                    end else begin
                        row_q <= row_q + 1'b1;
                    end
                end
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rlv_run_engine.sv
// Holds the run being painted and registers the pixel outputs. A new run may
// be loaded in the same cycle as the last pixel of the old one. Any leftover
// run is dropped by flush.
module rlv_run_engine
    import rlv_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_active,
    input  logic                flush,
    input  logic                load,
    input  logic [RUN_W-1:0]    load_len,
    input  logic [COLOUR_W-1:0] load_colour,
    output logic                run_idle,
    output logic                run_last,
    output logic [RUN_W-1:0]    run_left,
    output logic [COLOUR_W-1:0] pix_colour,
    output logic                pix_de
);
    logic [RUN_W-1:0]    left_q;
    logic [COLOUR_W-1:0] hue_q;
    logic                take;

    assign take     = pix_active && (left_q != '0);
    assign run_idle = (left_q == '0);
    assign run_last = (left_q == RUN_W'(1));
    assign run_left = left_q;

    // Run bookkeeping: flush, load or count down one painted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            hue_q  <= '0;
        end else if (flush) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_len;
            hue_q  <= load_colour;
        end else if (take) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Output register: colour only for painted pixels, enable follows active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_colour <= '0;
            pix_de     <= 1'b0;
        end else begin
            pix_colour <= take ? hue_q : '0;
            pix_de     <= pix_active;
        end
    end
endmodule

// File: rtl/rlv_stream_seq.sv
// Stream sequencer: decides when a word is accepted, tracks the address of
// the word being offered, and stores the first addresses of the current row
// and frame. It runs row repeats, stop and frame doubling through rewinds.
// Assumes the source follows a rewind on the same edge as this block.
module rlv_stream_seq
    import rlv_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  word_kind_e        kind,
    input  logic [REP_W-1:0]  rep_count,
    input  logic              frame_start,
    input  logic              frame_repeat,
    input  logic              pix_active,
    input  logic              run_idle,
    input  logic              run_last,
    input  logic              at_row_start,
    input  logic              at_row_last,
    input  logic              frame_done,
    output logic              word_ready,
    output logic              load,
    output logic              rewind_req,
    output logic [ADDR_W-1:0] rewind_addr,
    output logic              stop_flag,
    output logic              pass2_flag
);
    logic [ADDR_W-1:0] head_addr_q;
    logic [ADDR_W-1:0] row_base_q;
    logic [ADDR_W-1:0] frame_base_q;
    logic [REP_W-1:0]  rep_left_q;
    logic              rep_busy_q;
    logic              stopped_q;
    logic              pass2_q;
    logic              rw_q;
    logic [ADDR_W-1:0] rw_addr_q;

    logic              slot_free;
    logic              take;
    logic              row_edge;
    logic              rw_set;
    logic [ADDR_W-1:0] rw_target;

    assign slot_free  = run_idle || (pix_active && run_last && !at_row_last);
    assign word_ready = !rw_q && !frame_start && !stopped_q && slot_free
                        && !(frame_done && kind == WK_RUN);
    assign take       = word_valid && word_ready;
    assign load       = take && (kind == WK_RUN);
    assign row_edge   = at_row_start && run_idle;

    assign rewind_req  = rw_q;
    assign rewind_addr = rw_addr_q;
    assign stop_flag   = stopped_q;
    assign pass2_flag  = pass2_q;

    // Rewind decision: frame doubling, restart after stop, or row repeat.
    always_comb begin
        rw_set    = 1'b0;
        rw_target = '0;
        if (frame_start) begin
            if (frame_repeat && !pass2_q) begin
                rw_set    = 1'b1;
                rw_target = frame_base_q;
            end else if (stopped_q) begin
                rw_set = 1'b1;
            end
        end else if (take && kind == WK_REPEAT) begin
            if (rep_busy_q ? (rep_left_q != '0) : (rep_count != '0)) begin
                rw_set    = 1'b1;
                rw_target = row_base_q;
            end
        end
    end

    // Registered rewind request towards the source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_q      <= 1'b0;
            rw_addr_q <= '0;
        end else begin
            rw_q      <= rw_set;
            rw_addr_q <= rw_target;
        end
    end

    // Address of the word offered now: follows rewinds and acceptances.
    always_ff @(posedge clk) begin
        if (!rst_n)
            head_addr_q <= '0;
        else if (rw_q)
            head_addr_q <= rw_addr_q;
        else if (take)
            head_addr_q <= head_addr_q + 1'b1;
    end

    // Frame-level state: stop flag, doubling pass and frame start address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped_q    <= 1'b0;
            pass2_q      <= 1'b1;
            frame_base_q <= '0;
        end else if (frame_start) begin
            if (frame_repeat && !pass2_q) begin
                pass2_q   <= 1'b1;
                stopped_q <= 1'b0;
            end else if (stopped_q) begin
                pass2_q      <= 1'b0;
                stopped_q    <= 1'b0;
                frame_base_q <= '0;
            end else begin
                pass2_q      <= 1'b0;
                frame_base_q <= head_addr_q;
            end
        end else if (take && kind == WK_STOP) begin
            stopped_q <= 1'b1;
        end
    end

    // Row-level state: first run address of the row and the repeat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_base_q <= '0;
            rep_left_q <= '0;
            rep_busy_q <= 1'b0;
        end else if (frame_start) begin
            rep_busy_q <= 1'b0;
            rep_left_q <= '0;
        end else if (take) begin
            if (kind == WK_RUN && row_edge)
                row_base_q <= head_addr_q;
            if (kind == WK_REPEAT) begin
                if (!rep_busy_q) begin
                    if (rep_count != '0) begin
                        rep_busy_q <= 1'b1;
                        rep_left_q <= rep_count - 1'b1;
                    end
                end else if (rep_left_q != '0) begin
                    rep_left_q <= rep_left_q - 1'b1;
                end else begin
                    rep_busy_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rle_video_decoder.sv
// Top level of the run-length video pixel decoder: connects the word
// classifier, raster tracker, run engine and stream sequencer. Expects a
// 640x480 raster by default, at least three blanking cycles between rows and
// a frame_start pulse in vertical blanking.
module rle_video_decoder
    import rlv_pkg::*;
#(
    parameter int LINE_PIXELS = 640,
    parameter int FRAME_ROWS  = 480,
    parameter int ADDR_W      = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [15:0]       word_data,
    output logic              word_ready,
    input  logic              pix_active,
    input  logic              frame_start,
    input  logic              frame_repeat,
    output logic              rewind_req,
    output logic [ADDR_W-1:0] rewind_addr,
    output logic [5:0]        pix_colour,
    output logic              pix_de
);
    word_kind_e          kind;
    logic [RUN_W-1:0]    run_len;
    logic [COLOUR_W-1:0] word_colour;
    logic [REP_W-1:0]    rep_count;
    logic                at_row_start;
    logic                at_row_last;
    logic                frame_done;
    logic                run_idle;
    logic                run_last;
    logic [RUN_W-1:0]    run_left;
    logic                load;
    logic                stop_flag;
    logic                pass2_flag;

    rlv_word_class #(.LINE_PIXELS(LINE_PIXELS)) u_class (
        .word      (word_data),
        .kind      (kind),
        .run_len   (run_len),
        .colour    (word_colour),
        .rep_count (rep_count)
    );

    rlv_raster_track #(.LINE_PIXELS(LINE_PIXELS), .FRAME_ROWS(FRAME_ROWS)) u_raster (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_active   (pix_active),
        .frame_start  (frame_start),
        .at_row_start (at_row_start),
        .at_row_last  (at_row_last),
        .frame_done   (frame_done)
    );

    rlv_run_engine u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_active  (pix_active),
        .flush       (frame_start),
        .load        (load),
        .load_len    (run_len),
        .load_colour (word_colour),
        .run_idle    (run_idle),
        .run_last    (run_last),
        .run_left    (run_left),
        .pix_colour  (pix_colour),
        .pix_de      (pix_de)
    );

    rlv_stream_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_valid   (word_valid),
        .kind         (kind),
        .rep_count    (rep_count),
        .frame_start  (frame_start),
        .frame_repeat (frame_repeat),
        .pix_active   (pix_active),
        .run_idle     (run_idle),
        .run_last     (run_last),
        .at_row_start (at_row_start),
        .at_row_last  (at_row_last),
        .frame_done   (frame_done),
        .word_ready   (word_ready),
        .load         (load),
        .rewind_req   (rewind_req),
        .rewind_addr  (rewind_addr),
        .stop_flag    (stop_flag),
        .pass2_flag   (pass2_flag)
    );
endmodule

// File: rtl/rlv_checker.sv
// Protocol and behaviour properties for rle_video_decoder, bound to the top.
module rlv_checker #(
    parameter int LINE_PIXELS = 640,
    parameter int ADDR_W      = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_ready,
    input logic              rewind_req,
    input logic [ADDR_W-1:0] rewind_addr,
    input logic              pix_de,
    input logic [5:0]        pix_colour,
    input logic              pix_active,
    input logic              frame_start,
    input logic              frame_repeat,
    input logic              stop_flag,
    input logic              pass2_flag,
    input logic [9:0]        run_left
);
    AST_REWIND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rewind_req |=> !rewind_req); // R7
    AST_REWIND_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n) rewind_req |-> !word_ready); // R7
    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n) !pix_de |-> pix_colour == 6'd0); // R2
    AST_DE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) pix_active |=> pix_de); // R2
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) stop_flag |-> !word_ready); // R5
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && stop_flag && !(frame_repeat && !pass2_flag)) |=> (rewind_req && rewind_addr == '0)); // R5
    AST_DOUBLE_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && frame_repeat && !pass2_flag) |=> rewind_req); // R6
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) run_left <= 10'(LINE_PIXELS)); // R1
endmodule

bind rle_video_decoder rlv_checker #(.LINE_PIXELS(LINE_PIXELS), .ADDR_W(ADDR_W)) i_rlv_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_ready   (word_ready),
    .rewind_req   (rewind_req),
    .rewind_addr  (rewind_addr),
    .pix_de       (pix_de),
    .pix_colour   (pix_colour),
    .pix_active   (pix_active),
    .frame_start  (frame_start),
    .frame_repeat (frame_repeat),
    .stop_flag    (stop_flag),
    .pass2_flag   (pass2_flag),
    .run_left     (run_left)
);

// File: tb/test_rle_video_decoder.sv
module test_rle_video_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int LINE  = 16;
    localparam int ROWS  = 4;
    localparam int AW    = 8;
    localparam int HBLANK = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          word_valid;
    logic [15:0]   word_data;
    logic          word_ready;
    logic          pix_active = 1'b0;
    logic          frame_start = 1'b0;
    logic          frame_repeat = 1'b0;
    logic          rewind_req;
    logic [AW-1:0] rewind_addr;
    logic [5:0]    pix_colour;
    logic          pix_de;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [15:0] mem [0:31];
    logic [AW-1:0] ptr;

    int    exp_pix [$];
    string exp_pix_tag [$];
    int    exp_rw [$];
    string exp_rw_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rle_video_decoder #(.LINE_PIXELS(LINE), .FRAME_ROWS(ROWS), .ADDR_W(AW)) i_rle_video_decoder (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .pix_active(pix_active), .frame_start(frame_start),
        .frame_repeat(frame_repeat), .rewind_req(rewind_req), .rewind_addr(rewind_addr),
        .pix_colour(pix_colour), .pix_de(pix_de)
    );

    // Stream source model: in-order word memory that follows rewinds.
    assign word_valid = 1'b1;
    assign word_data  = mem[ptr[4:0]];
    always @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else if (rewind_req) ptr <= rewind_addr;
        else if (word_valid && word_ready) ptr <= ptr + 1'b1;
    end

    function automatic logic [15:0] enc(input int len, input int c);
        return {10'(len), 6'(c)};
    endfunction

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push_run(input int len, input int c, input string tag);
        for (int i = 0; i < len; i++) begin
            exp_pix.push_back(c);
            exp_pix_tag.push_back(tag);
        end
    endtask

    task automatic push_rw(input int a, input string tag);
        exp_rw.push_back(a);
        exp_rw_tag.push_back(tag);
    endtask

    // Frame A: row0 two runs, row1 shown three times via repeat N=2.
    task automatic push_frame_a(input string tag);
        push_run(4, 1, tag); push_run(12, 2, tag);
        push_run(16, 3, tag);
        push_run(16, 3, "R4"); push_run(16, 3, "R4");
        push_rw(2, "R4"); push_rw(2, "R4");
    endtask

    // Frame B: junk word before row1, repeat N=0 after row1, stop at end.
    task automatic push_frame_b(input string tag);
        push_run(2, 4, tag); push_run(2, 5, tag); push_run(12, 6, tag);
        push_run(8, 7, "R8"); push_run(8, 8, "R8");
        push_run(16, 9, "R4");
        push_run(6, 10, tag); push_run(10, 11, tag);
    endtask

    task automatic drive_row();
        for (int i = 0; i < LINE; i++) begin
            @(posedge clk); #1 pix_active = 1'b1;
        end
        @(posedge clk); #1 pix_active = 1'b0;
        repeat (HBLANK - 1) @(posedge clk);
    endtask

    task automatic show_frame();
        @(posedge clk); #1 frame_start = 1'b1;
        @(posedge clk); #1 frame_start = 1'b0;
        repeat (4) @(posedge clk);
        for (int r = 0; r < ROWS; r++) drive_row();
        repeat (4) @(posedge clk);
    endtask

    // Monitor: pixels against the scoreboard, blank colour, rewinds.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (pix_de) begin
                if (exp_pix.size() == 0) begin
                    check("R1 unexpected pixel", 1'b0, pix_colour, -1);
                end else begin
                    automatic int e = exp_pix.pop_front();
                    automatic string t = exp_pix_tag.pop_front();
                    check(t, pix_colour == 6'(e), pix_colour, e);
                end
            end else begin
                check("R2 blank colour", pix_colour == 6'd0, pix_colour, 0);
            end
            if (rewind_req) begin
                check("R7 ready low on rewind", !word_ready, word_ready, 0);
                if (exp_rw.size() == 0) begin
                    check("R7 unexpected rewind", 1'b0, rewind_addr, -1);
                end else begin
                    automatic int e = exp_rw.pop_front();
                    automatic string t = exp_rw_tag.pop_front();
                    check(t, rewind_addr == AW'(e), rewind_addr, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 16'h0000;
        mem[0]  = enc(4, 1);  mem[1]  = enc(12, 2); mem[2] = enc(16, 3);
        mem[3]  = 16'hF802;   mem[4]  = 16'hAF05;
        mem[5]  = enc(2, 4);  mem[6]  = enc(2, 5);  mem[7] = enc(12, 6);
        mem[8]  = 16'h0000;   mem[9]  = enc(8, 7);  mem[10] = enc(8, 8);
        mem[11] = 16'hF800;   mem[12] = enc(16, 9);
        mem[13] = enc(6, 10); mem[14] = enc(10, 11); mem[15] = 16'hFFC0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 pix_de after reset", !pix_de, pix_de, 0);
        check("R9 colour after reset", pix_colour == 0, pix_colour, 0);
        check("R9 rewind after reset", !rewind_req, rewind_req, 0);
        check("R9 no run taken before frame", !word_ready, word_ready, 0);
        check("R9 fetch address zero", word_data == enc(4, 1), word_data, enc(4, 1));

        // R3: active pixels before any frame start are dark
        push_run(LINE, 0, "R3");
        drive_row();

        // Frame 1: A
        push_frame_a("R1");
        show_frame();
        @(negedge clk);
        // R10: next frame's first run is held, junk control word already taken
        check("R10 run held", !word_ready, word_ready, 0);
        check("R10 head word", word_data == enc(2, 4), word_data, enc(2, 4));

        // Frame 2: B, ending with stop
        push_frame_b("R1");
        show_frame();
        @(negedge clk);
        check("R5 stopped not ready", !word_ready, word_ready, 0);

        // Frame 3: restart from 0
        push_rw(0, "R5");
        push_frame_a("R5");
        show_frame();

        // Frame 4: doubling on, frame A shown again
        #1 frame_repeat = 1'b1;
        push_rw(0, "R6");
        push_frame_a("R6");
        show_frame();

        // Frame 5: new content B; frame 6: B again from address 5
        push_frame_b("R6");
        show_frame();
        push_rw(5, "R6");
        push_frame_b("R6");
        show_frame();

        // Frame 7: second pass done and stopped, restart at 0
        push_rw(0, "R5");
        push_frame_a("R5");
        show_frame();

        repeat (4) @(negedge clk);
        check("R1 all pixels produced", exp_pix.size() == 0, exp_pix.size(), 0);
        check("R4 all rewinds seen", exp_rw.size() == 0, exp_rw.size(), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule